// File: doc/BRIEF.md
# Write-Back Data Cache Policy Controller

This block is a small direct-mapped, write-back data cache controller. For every CPU access it decides whether the access is served from the line store, fills a line, goes straight to memory, or first writes back and/or invalidates the line it hits. A 32-bit control word selects its behaviour:

- a global enable;
- a mode in which misses never allocate;
- a mode in which an explicit push command leaves the pushed line resident;
- a mode that restricts lookups to the lower half of the sets.

The CPU side is a pulse-request / one-cycle-acknowledge port. It carries a lock flag for read-modify-write operands and a push flag for explicit write-back commands. The memory side issues one single-word line transfer at a time, either a read (fill or bypass read) or a write (push or bypass write). Each transfer is held until the memory acknowledges it.

Each line is one data word. The address splits into a byte offset, a set index and a tag. The stored tag keeps the top index bit as well, so that a line stays correct when the half-capacity mode is switched on or off.

Top module: `dcache_policy_ctrl`

## Requirements
- R1: The control word is written as a whole through `cfg_we`/`cfg_wdata`. Bit 31 is enable, bit 30 is no-allocate, bit 28 is keep-after-push and bit 27 is half-capacity. All other bits read back as 0. Reset clears the whole word.
- R2: With enable at 0, every read or write (locked or not) becomes exactly one memory transfer to the request address, and the line store is not modified.
- R3: A read hit returns the stored word with no memory transfer. A write hit replaces the stored word, marks the line dirty and makes no memory transfer.
- R4: With no-allocate at 0, a read miss fills the line from memory and returns the fetched word. A write miss fills the line, merges the written word and leaves the line dirty.
- R5: With no-allocate at 1, read and write misses go to memory as one transfer each and install nothing.
- R6: A locked access that misses goes to memory and installs nothing, whatever the mode bits.
- R7: A locked access that hits a clean line invalidates it, with no write-back, and then goes to memory.
- R8: A locked access that hits a dirty line first writes the line back to its own address, then invalidates it, then performs the operand transfer.
- R9: On an allocating miss whose victim is valid and dirty, the victim write-back completes before the fill read starts. The acknowledge comes only after the fill.
- R10: A push command with keep-after-push at 0 writes back a dirty hit line and invalidates any hit line. On a miss it does nothing.
- R11: A push command with keep-after-push at 1 writes back a dirty hit line and leaves it valid and clean. A clean hit causes no transfer.
- R12: With half-capacity at 1, the top index bit is forced to 0. Lines held in the upper half of the sets are not looked up, but they survive and hit again once the mode is cleared.
- R13: Reset clears only the control word. Tags, valid and dirty bits and data stay intact.
- R14: `cpu_ack` is a one-cycle pulse, and `cpu_rdata` is valid in that cycle. `mem_req`, `mem_addr` and `mem_we` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | New control word |
| cfg_rdata | output | 32 | Current control word (unused bits 0) |
| cpu_req | input | 1 | One-cycle access request, taken when idle |
| cpu_push | input | 1 | Request is a push command for the addressed line |
| cpu_we | input | 1 | Request is a write |
| cpu_lock | input | 1 | Request is a locked operand |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ack | output | 1 | Access complete (one cycle) |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W | Transfer address |
| mem_wdata | output | DATA_W | Write data of the transfer |
| mem_ack | input | 1 | Transfer complete (one cycle) |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench targets these cases:
- **Locked hit on a dirty line.** A design that skips the write-back loses data. A design that keeps the line valid makes the next read hit where it should miss.
- **Dirty victim on an allocating miss.** The order of the two transfers is compared. Issuing the fill first, or dropping the push, shows up in the transfer log.
- **Half-capacity mode.** A line is left in the upper half of the sets, the mode is turned on, and the line is then read again with the mode off. A design that clears or aliases those sets returns the wrong word.
- **Reset in the middle of the run.** A dirty line must survive it. A design that resets the arrays turns the later hit into a fill of stale memory data.

// File: rtl/dcp_pkg.sv
`timescale 1ns/1ps
package dcp_pkg;
  // control word bit positions (software-visible layout)
  localparam int unsigned CFG_W        = 32;
  localparam int unsigned CFG_EN_BIT   = 31;
  localparam int unsigned CFG_NA_BIT   = 30;
  localparam int unsigned CFG_KEEP_BIT = 28;
  localparam int unsigned CFG_HALF_BIT = 27;
  localparam logic [CFG_W-1:0] CFG_MASK =
    (CFG_W'(1) << CFG_EN_BIT) | (CFG_W'(1) << CFG_NA_BIT) |
    (CFG_W'(1) << CFG_KEEP_BIT) | (CFG_W'(1) << CFG_HALF_BIT);

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_PUSH, S_FILL, S_BYP, S_DONE
  } dcp_state_e;

  // what follows a write-back
  typedef enum logic [1:0] { G_DONE, G_FILL, G_BYP } dcp_goal_e;
endpackage

// File: rtl/dcp_ctrl_reg.sv
`timescale 1ns/1ps
module dcp_ctrl_reg
  import dcp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             mode_en,
  output logic             mode_noalloc,
  output logic             mode_keep,
  output logic             mode_half
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst)         word_q <= '0;
    else if (cfg_we) word_q <= cfg_wdata & CFG_MASK;
  end

  assign cfg_rdata    = word_q;
  assign mode_en      = word_q[CFG_EN_BIT];
  assign mode_noalloc = word_q[CFG_NA_BIT];
  assign mode_keep    = word_q[CFG_KEEP_BIT];
  assign mode_half    = word_q[CFG_HALF_BIT];

  // R1: a reset cycle leaves the word cleared
  p_cfg_cleared_r1: assert property (@(posedge clk) rst |=> (cfg_rdata == '0));
endmodule

// File: rtl/dcp_line_store.sv
`timescale 1ns/1ps
module dcp_line_store #(
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned TAG_W  = 28,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int unsigned SETS = 1 << IDX_W;

  // no reset on purpose: contents survive a hardware reset
  logic [SETS-1:0]   valid_a;
  logic [SETS-1:0]   dirty_a;
  logic [TAG_W-1:0]  tag_a  [SETS];
  logic [DATA_W-1:0] data_a [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      valid_a[wr_idx] <= wr_valid;
      dirty_a[wr_idx] <= wr_dirty;
      tag_a[wr_idx]   <= wr_tag;
      data_a[wr_idx]  <= wr_data;
    end
  end

  assign rd_valid = valid_a[rd_idx];
  assign rd_dirty = dirty_a[rd_idx];
  assign rd_tag   = tag_a[rd_idx];
  assign rd_data  = data_a[rd_idx];
endmodule

// File: rtl/dcache_policy_ctrl.sv
`timescale 1ns/1ps
module dcache_policy_ctrl
  import dcp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cpu_req,
  input  logic              cpu_push,
  input  logic              cpu_we,
  input  logic              cpu_lock,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  // stored tag keeps the top index bit so half mode stays unambiguous
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W + 1;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a, input logic half);
    logic [IDX_W-1:0] s;
    s = a[OFF_W +: IDX_W];
    if (half) s[IDX_W-1] = 1'b0;
    return s;
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] s);
    return {t, s[IDX_W-2:0], {OFF_W{1'b0}}};
  endfunction

  logic mode_en, mode_noalloc, mode_keep, mode_half;

  dcp_ctrl_reg u_ctrl (
    .clk, .rst, .cfg_we, .cfg_wdata, .cfg_rdata,
    .mode_en, .mode_noalloc, .mode_keep, .mode_half
  );

  dcp_state_e        st, nxt;
  dcp_goal_e         goal_q, goal_d;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_wdata, rdata_q, rdata_d;
  logic              cap_we, cap_lock, cap_push, rdata_ld;

  logic [IDX_W-1:0]  cap_set;
  logic [TAG_W-1:0]  cap_tag;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [DATA_W-1:0] rd_data;
  logic              st_we, w_valid, w_dirty;
  logic [TAG_W-1:0]  w_tag;
  logic [DATA_W-1:0] w_data;

  // named internal events
  logic hit, push_done, fill_done, push_inval;

  assign cap_set    = set_of(cap_addr, mode_half);
  assign cap_tag    = tag_of(cap_addr);
  assign hit        = rd_valid && (rd_tag == cap_tag);
  assign push_done  = (st == S_PUSH) && mem_ack;
  assign fill_done  = (st == S_FILL) && mem_ack;
  assign push_inval = cap_push ? !mode_keep : cap_lock;

  dcp_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk, .rd_idx(cap_set), .rd_valid, .rd_dirty, .rd_tag, .rd_data,
    .wr_en(st_we), .wr_idx(cap_set), .wr_valid(w_valid), .wr_dirty(w_dirty),
    .wr_tag(w_tag), .wr_data(w_data)
  );

  always_comb begin
    nxt      = st;
    goal_d   = G_DONE;
    st_we    = 1'b0;
    w_valid  = rd_valid;
    w_dirty  = rd_dirty;
    w_tag    = rd_tag;
    w_data   = rd_data;
    rdata_ld = 1'b0;
    rdata_d  = mem_rdata;
    case (st)
      S_IDLE: if (cpu_req) nxt = S_LOOK;
      S_LOOK: begin
        if (cap_push) begin
          if (hit && rd_dirty) begin nxt = S_PUSH; goal_d = G_DONE; end
          else begin
            nxt = S_DONE;
            if (hit && !mode_keep) begin st_we = 1'b1; w_valid = 1'b0; end
          end
        end else if (!mode_en) begin
          nxt = S_BYP;
        end else if (cap_lock) begin
          if (hit && rd_dirty) begin nxt = S_PUSH; goal_d = G_BYP; end
          else begin
            nxt = S_BYP;
            if (hit) begin st_we = 1'b1; w_valid = 1'b0; end
          end
        end else if (hit) begin
          nxt = S_DONE;
          if (cap_we) begin st_we = 1'b1; w_data = cap_wdata; w_dirty = 1'b1; end
          else begin rdata_ld = 1'b1; rdata_d = rd_data; end
        end else if (mode_noalloc) begin
          nxt = S_BYP;
        end else if (rd_valid && rd_dirty) begin
          nxt = S_PUSH; goal_d = G_FILL;
        end else begin
          nxt = S_FILL;
        end
      end
      S_PUSH: if (mem_ack) begin
        st_we   = 1'b1;
        w_dirty = 1'b0;
        w_valid = rd_valid && !push_inval;
        case (goal_q)
          G_FILL:  nxt = S_FILL;
          G_BYP:   nxt = S_BYP;
          default: nxt = S_DONE;
        endcase
      end
      S_FILL: if (mem_ack) begin
        st_we    = 1'b1;
        w_valid  = 1'b1;
        w_tag    = cap_tag;
        w_dirty  = cap_we;
        w_data   = cap_we ? cap_wdata : mem_rdata;
        rdata_ld = 1'b1;
        nxt      = S_DONE;
      end
      S_BYP: if (mem_ack) begin rdata_ld = 1'b1; nxt = S_DONE; end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && cpu_req) begin
      cap_addr  <= cpu_addr;
      cap_wdata <= cpu_wdata;
      cap_we    <= cpu_we;
      cap_lock  <= cpu_lock;
      cap_push  <= cpu_push;
    end
    if (st == S_LOOK) goal_q  <= goal_d;
    if (rdata_ld)     rdata_q <= rdata_d;
  end

  assign cpu_ack   = (st == S_DONE);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (st == S_PUSH) || (st == S_FILL) || (st == S_BYP);
  assign mem_we    = (st == S_PUSH) || ((st == S_BYP) && cap_we);
  assign mem_wdata = (st == S_PUSH) ? rd_data : cap_wdata;
  always_comb begin
    case (st)
      S_PUSH:  mem_addr = line_base(rd_tag, cap_set);
      S_FILL:  mem_addr = line_base(cap_tag, cap_set);
      default: mem_addr = cap_addr;
    endcase
  end

  // R14: acknowledge lasts one cycle
  p_ack_pulse_r14: assert property (@(posedge clk) disable iff (rst)
    cpu_ack |=> !cpu_ack);
  // R14: a pending memory transfer keeps its request and address
  p_mem_hold_r14: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R2: with the cache off, only push commands may touch the store
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    st_we |-> (mode_en || cap_push));
  // R6: a line is never installed for a locked or no-allocate access
  p_no_alloc_lock_r6: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> (!cap_lock && !mode_noalloc));
  // R9: the victim is clean while the fill is on the bus
  p_victim_clean_r9: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL) |-> !(rd_valid && rd_dirty));
  // R7: a locked operand on the bus no longer hits the store
  p_lock_hit_gone_r7: assert property (@(posedge clk) disable iff (rst)
    ((st == S_BYP) && cap_lock && mode_en) |-> !hit);
  // R11: a kept line is clean when the push command completes
  p_keep_clean_r11: assert property (@(posedge clk) disable iff (rst)
    ((st == S_DONE) && cap_push && mode_keep) |-> !(hit && rd_dirty));
endmodule

// File: tb/dcache_policy_ctrl_bench.sv
`timescale 1ns/1ps
module dcache_policy_ctrl_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int IW = 3;
  localparam int OW = 2;
  localparam int TW = AW - OW - IW + 1;
  localparam int NS = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic cpu_req = 1'b0, cpu_push = 1'b0, cpu_we = 1'b0, cpu_lock = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic cpu_ack;
  logic [DW-1:0] cpu_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  dcache_policy_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_dcache_policy_ctrl (
    .clk, .rst, .cfg_we, .cfg_wdata, .cfg_rdata,
    .cpu_req, .cpu_push, .cpu_we, .cpu_lock, .cpu_addr, .cpu_wdata,
    .cpu_ack, .cpu_rdata,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_ack, .mem_rdata
  );

  int nchk = 0;
  int nerr = 0;
  bit init_phase = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [31:0] dut_mem [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  int nops = 0;
  logic        l_we   [16];
  logic [31:0] l_addr [16];
  logic [31:0] l_dat  [16];

  function automatic logic [31:0] mdef(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0000;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        if (!init_phase) dut_mem[mem_addr] = mem_wdata;
      end else begin
        mem_rdata <= dut_mem.exists(mem_addr) ? dut_mem[mem_addr] : mdef(mem_addr);
      end
      if (nops < 16) begin
        l_we[nops] = mem_we; l_addr[nops] = mem_addr; l_dat[nops] = mem_wdata;
      end
      nops++;
    end
  end

  // ---------------- reference model ----------------
  bit m_en, m_na, m_keep, m_half;
  bit bv [NS];
  bit bd [NS];
  logic [TW-1:0] bt [NS];
  logic [31:0] bdat [NS];
  int en_ops;
  logic        e_we   [16];
  logic [31:0] e_addr [16];
  logic [31:0] e_dat  [16];

  function automatic int setof(input logic [31:0] a);
    int s;
    s = int'((a >> OW) % NS);
    if (m_half) s = s % (NS / 2);
    return s;
  endfunction

  function automatic logic [TW-1:0] tagof(input logic [31:0] a);
    return TW'(a >> (OW + IW - 1));
  endfunction

  function automatic logic [31:0] lbase(input logic [TW-1:0] t, input int s);
    return (32'(t) << (OW + IW - 1)) | (32'(s % (NS / 2)) << OW);
  endfunction

  function automatic logic [31:0] refrd(input logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : mdef(a);
  endfunction

  task automatic addop(input bit we, input logic [31:0] a, input logic [31:0] d);
    e_we[en_ops] = we; e_addr[en_ops] = a; e_dat[en_ops] = d;
    if (we) ref_mem[a] = d;
    en_ops++;
  endtask

  task automatic bypass(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        inout logic [31:0] rd);
    addop(we, a, wd);
    if (!we) rd = refrd(a);
  endtask

  task automatic model(input bit p, input bit we, input bit lk, input logic [31:0] a,
                       input logic [31:0] wd, output logic [31:0] rd);
    int s;
    logic [TW-1:0] t;
    bit h;
    en_ops = 0; rd = '0;
    s = setof(a); t = tagof(a);
    h = bv[s] && (bt[s] == t);
    if (p) begin
      if (h) begin
        if (bd[s]) addop(1'b1, lbase(bt[s], s), bdat[s]);
        bd[s] = 1'b0;
        if (!m_keep) bv[s] = 1'b0;
      end
    end else if (!m_en) bypass(we, a, wd, rd);
    else if (lk) begin
      if (h) begin
        if (bd[s]) addop(1'b1, lbase(bt[s], s), bdat[s]);
        bv[s] = 1'b0; bd[s] = 1'b0;
      end
      bypass(we, a, wd, rd);
    end else if (h) begin
      if (we) begin bdat[s] = wd; bd[s] = 1'b1; end
      else rd = bdat[s];
    end else if (m_na) bypass(we, a, wd, rd);
    else begin
      if (bv[s] && bd[s]) addop(1'b1, lbase(bt[s], s), bdat[s]);
      addop(1'b0, lbase(t, s), '0);
      rd = refrd(lbase(t, s));
      bv[s] = 1'b1; bt[s] = t; bd[s] = we;
      bdat[s] = we ? wd : rd;
    end
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic set_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_en = v[31]; m_na = v[30]; m_keep = v[28]; m_half = v[27];
  endtask

  task automatic access(input string r, input bit p, input bit we, input bit lk,
                        input logic [31:0] a, input logic [31:0] wd);
    logic [31:0] exp_rd, got;
    int waitc;
    bit seen;
    if (!init_phase) model(p, we, lk, a, wd, exp_rd);
    nops = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_push = p; cpu_we = we; cpu_lock = lk; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    waitc = 0; seen = 1'b0;
    while (!seen && waitc < 200) begin
      if (cpu_ack) seen = 1'b1;
      else begin @(negedge clk); waitc++; end
    end
    got = cpu_rdata;
    @(negedge clk);
    if (init_phase) return;
    chk({r, "/R14 ack seen"}, 32'(seen), 32'd1);
    chk({r, "/R14 ack one cycle"}, 32'(cpu_ack), 32'd0);
    chk({r, " transfer count"}, 32'(nops), 32'(en_ops));
    for (int i = 0; i < en_ops && i < nops && i < 16; i++) begin
      chk({r, " transfer dir"}, 32'(l_we[i]), 32'(e_we[i]));
      chk({r, " transfer addr"}, l_addr[i], e_addr[i]);
      if (e_we[i]) chk({r, " transfer data"}, l_dat[i], e_dat[i]);
    end
    if (!p && !we) chk({r, " read data"}, got, exp_rd);
  endtask

  task automatic init_sweep();
    init_phase = 1'b1;
    set_cfg(32'h8000_0000);
    for (int s = 0; s < NS; s++) begin
      access("init", 1'b0, 1'b0, 1'b0, 32'(s) << OW, '0);
      access("init", 1'b1, 1'b0, 1'b0, 32'(s) << OW, '0);
    end
    for (int s = 0; s < NS; s++) begin bv[s] = 1'b0; bd[s] = 1'b0; end
    init_phase = 1'b0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state();
    chk("R1 reset word", cfg_rdata, 32'h0);
    chk("R14 no ack after reset", 32'(cpu_ack), 32'd0);
    chk("R14 no mem req after reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_cfg_rw();
    set_cfg(32'hFFFF_FFFF);
    chk("R1 all ones", cfg_rdata, 32'hD800_0000);
    set_cfg(32'h1234_5678);
    chk("R1 mixed", cfg_rdata, 32'h1000_0000);
  endtask

  task automatic t_disabled();
    set_cfg(32'h0000_0000);
    access("R2 read off", 1'b0, 1'b0, 1'b0, 32'h0000_1004, '0);
    access("R2 write off", 1'b0, 1'b1, 1'b0, 32'h0000_1004, 32'hAAAA_0001);
    access("R2 locked off", 1'b0, 1'b0, 1'b1, 32'h0000_1004, '0);
    set_cfg(32'h8000_0000);
    access("R2 nothing kept", 1'b0, 1'b0, 1'b0, 32'h0000_1004, '0);
  endtask

  task automatic t_alloc_hits();
    set_cfg(32'h8000_0000);
    access("R4 read miss fill", 1'b0, 1'b0, 1'b0, 32'h0000_2008, '0);
    access("R3 read hit", 1'b0, 1'b0, 1'b0, 32'h0000_2008, '0);
    access("R3 write hit", 1'b0, 1'b1, 1'b0, 32'h0000_2008, 32'hBEEF_0002);
    access("R3 read after write", 1'b0, 1'b0, 1'b0, 32'h0000_2008, '0);
    access("R4 write miss merge", 1'b0, 1'b1, 1'b0, 32'h0000_300C, 32'hC0DE_0003);
    access("R4 read merged", 1'b0, 1'b0, 1'b0, 32'h0000_300C, '0);
  endtask

  task automatic t_victim();
    set_cfg(32'h8000_0000);
    access("R9 dirty victim push then fill", 1'b0, 1'b0, 1'b0, 32'h0000_4008, '0);
    access("R9 old line reloads", 1'b0, 1'b0, 1'b0, 32'h0000_2008, '0);
  endtask

  task automatic t_noalloc();
    set_cfg(32'hC000_0000);
    access("R5 read miss bypass", 1'b0, 1'b0, 1'b0, 32'h0000_5014, '0);
    access("R5 read miss again", 1'b0, 1'b0, 1'b0, 32'h0000_5014, '0);
    access("R5 write miss bypass", 1'b0, 1'b1, 1'b0, 32'h0000_5014, 32'h1111_0005);
    access("R5 read sees memory", 1'b0, 1'b0, 1'b0, 32'h0000_5014, '0);
  endtask

  task automatic t_lock();
    set_cfg(32'h8000_0000);
    access("R6 locked read miss", 1'b0, 1'b0, 1'b1, 32'h0000_6018, '0);
    access("R6 locked write miss", 1'b0, 1'b1, 1'b1, 32'h0000_6018, 32'h2222_0006);
    access("R6 no line left", 1'b0, 1'b0, 1'b0, 32'h0000_6018, '0);
    access("R7 locked write clean hit", 1'b0, 1'b1, 1'b1, 32'h0000_6018, 32'h3333_0007);
    access("R7 line gone", 1'b0, 1'b0, 1'b0, 32'h0000_6018, '0);
    access("R8 make dirty", 1'b0, 1'b1, 1'b0, 32'h0000_6018, 32'h4444_0008);
    access("R8 locked read dirty hit", 1'b0, 1'b0, 1'b1, 32'h0000_6018, '0);
    access("R8 line gone", 1'b0, 1'b0, 1'b0, 32'h0000_6018, '0);
    set_cfg(32'hC000_0000);
    access("R6 locked miss noalloc", 1'b0, 1'b0, 1'b1, 32'h0000_7018, '0);
  endtask

  task automatic t_push();
    set_cfg(32'h8000_0000);
    access("R10 prep", 1'b0, 1'b1, 1'b0, 32'h0000_801C, 32'h5555_000A);
    access("R10 push dirty", 1'b1, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R10 invalidated", 1'b0, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R10 push clean", 1'b1, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R10 clean gone", 1'b0, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R10 push miss", 1'b1, 1'b0, 1'b0, 32'h0000_901C, '0);
    set_cfg(32'h9000_0000);
    access("R11 prep", 1'b0, 1'b1, 1'b0, 32'h0000_801C, 32'h6666_000B);
    access("R11 push keep", 1'b1, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R11 still hits", 1'b0, 1'b0, 1'b0, 32'h0000_801C, '0);
    access("R11 clean push quiet", 1'b1, 1'b0, 1'b0, 32'h0000_801C, '0);
  endtask

  task automatic t_half();
    set_cfg(32'h8000_0000);
    access("R12 upper fill", 1'b0, 1'b1, 1'b0, 32'h0000_A010, 32'h7777_000C);
    set_cfg(32'h8800_0000);
    access("R12 half miss", 1'b0, 1'b0, 1'b0, 32'h0000_A010, '0);
    access("R12 half hit", 1'b0, 1'b0, 1'b0, 32'h0000_A010, '0);
    access("R12 half alias", 1'b0, 1'b0, 1'b0, 32'h0000_A000, '0);
    set_cfg(32'h8000_0000);
    access("R12 upper survives", 1'b0, 1'b0, 1'b0, 32'h0000_A010, '0);
  endtask

  task automatic t_reset_keep();
    set_cfg(32'h8000_0000);
    access("R13 prep", 1'b0, 1'b1, 1'b0, 32'h0000_B004, 32'h8888_000D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    m_en = 0; m_na = 0; m_keep = 0; m_half = 0;
    chk("R13 word cleared", cfg_rdata, 32'h0);
    set_cfg(32'h8000_0000);
    access("R13 line kept", 1'b0, 1'b0, 1'b0, 32'h0000_B004, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_cfg_rw();
    init_sweep();
    t_disabled();
    t_alloc_hits();
    t_victim();
    t_noalloc();
    t_lock();
    t_push();
    t_half();
    t_reset_keep();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule